// File: doc/BRIEF.md
# Transmit-Enable Flush and Digital Power-Down Controller

This block sits in front of the interpolation datapath of a dual-channel DAC front end and decides, from a transmit-enable input, when that datapath carries live samples, when zeros are pushed through it, and when its digital engine may be gated off. If the enable goes inactive, the block first drives a zero-flush control so that the interpolation filters drain with zeros. If automatic power-down is enabled, it then asserts a digital power-down request once a flush long enough for the selected 2x, 4x or 8x filter chain has run. If automatic power-down is disabled, it keeps flushing and never powers down.

The enable input is asynchronous. It passes through a two-flop synchronizer, and an invert control can reverse its active sense. When the enable becomes active again at any point, the block returns to normal running and its flush counter restarts from zero. Two register-driven controls are combined into the power outputs. A sleep control turns off only the DAC output and leaves the reference powered. A full power-down control turns off the DAC output, the reference and the digital engine. A two-bit status output reports the current state.

Top module: `txen_pd_ctrl`

## Requirements
- R1: Reset puts the status at run (code 0) with flush_zero, digital_pd, dac_out_off and ref_pd all low. The state is held in run for as long as rst is high.
- R2: Enable becomes active when txen_in XOR txen_invert is 1. If it becomes active through txen_in, the status shows run (code 0) and flush_zero is low by the third rising edge after the change.
- R3: Enable becomes inactive when txen_in XOR txen_invert is 0. If it becomes inactive through txen_in, the status shows flushing (code 1) and flush_zero is high by the third rising edge after the change.
- R4: While autopd_en is 0, an inactive enable keeps the status at flushing with digital_pd low, however long it lasts.
- R5: With autopd_en at 1, the block spends exactly L cycles in flushing and then enters powered-down (code 2) with digital_pd high. L is 32, 64 or 128 for interp_sel 0 (2x), 1 (4x) or 2 (8x). Code 3 takes the 8x length.
- R6: txen_invert at 1 reverses the enable sense, so that txen_in high is inactive and txen_in low is active.
- R7: An active enable during flushing or powered-down returns the status to run. A flush that starts later runs its full length L.
- R8: Digital power-down on its own leaves dac_out_off and ref_pd low.
- R9: sleep_req raises dac_out_off and leaves ref_pd low.
- R10: full_pd_req raises dac_out_off, ref_pd and digital_pd, whatever the state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous active-high reset |
| txen_in | input | 1 | Asynchronous transmit-enable input |
| txen_invert | input | 1 | Reverses the active sense of txen_in |
| autopd_en | input | 1 | Enables power-down of the digital engine after a flush |
| interp_sel | input | 2 | Interpolation rate: 0=2x, 1=4x, 2=8x, 3=8x |
| sleep_req | input | 1 | Sleep control: DAC output off, reference kept on |
| full_pd_req | input | 1 | Full power-down control |
| flush_zero | output | 1 | Forces zeros into the interpolation datapath |
| digital_pd | output | 1 | Power-down request for the digital engine |
| dac_out_off | output | 1 | Turns the DAC output stage off |
| ref_pd | output | 1 | Powers down the reference |
| pd_state | output | 2 | Status: 0 run, 1 flushing, 2 powered-down |

## Verification
The hardest event to reach is the exact cycle of the move from flushing to powered-down. It sits L cycles after the enable change, behind the synchronizer, and the counter can be cleared in the middle. The stimulus counts rising edges from each input change and samples one cycle before and one cycle on the expected transition, for each of the three lengths. The 4x case enters the flush through the invert control, so it bypasses the synchronizer delay. The 8x case starts counting only when autopd_en rises during a flush that is already running. A second flush that follows an enable which came back mid-flush confirms that the counter restarts from zero.

// File: rtl/txpd_pkg.sv
package txpd_pkg;

    typedef enum logic [1:0] {
        ST_RUN   = 2'd0,
        ST_FLUSH = 2'd1,
        ST_DOWN  = 2'd2
    } pd_state_e;

    typedef enum logic [1:0] {
        INTERP_2X   = 2'd0,
        INTERP_4X   = 2'd1,
        INTERP_8X   = 2'd2,
        INTERP_RSVD = 2'd3
    } interp_e;

    typedef struct packed {
        logic flush_zero;
        logic digital_pd;
        logic dac_out_off;
        logic ref_pd;
    } pd_ctl_t;

    function automatic int unsigned flush_cycles(
        input logic [1:0]  sel,
        input int unsigned len_2x,
        input int unsigned len_4x,
        input int unsigned len_8x
    );
        case (interp_e'(sel))
            INTERP_2X: return len_2x;
            INTERP_4X: return len_4x;
            default:   return len_8x;
        endcase
    endfunction

endpackage

// File: rtl/txen_sync.sv
module txen_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic d_async,
    output logic q_sync
);
    logic [STAGES-1:0] chain;

    always_ff @(posedge clk) begin
        if (rst) chain <= '0;
        else     chain <= {chain[STAGES-2:0], d_async};
    end

    assign q_sync = chain[STAGES-1];
endmodule

// File: rtl/flush_timer.sv
module flush_timer #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic [CNT_W-1:0] limit,
    output logic             expired
);
    logic [CNT_W-1:0] cnt;

    assign expired = run && (cnt == limit - CNT_W'(1));

    always_ff @(posedge clk) begin
        if (rst || !run) cnt <= '0;
        else if (!expired) cnt <= cnt + CNT_W'(1);
    end
endmodule

// File: rtl/txen_fsm.sv
module txen_fsm
    import txpd_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      active,
    input  logic      autopd_en,
    input  logic      expired,
    output pd_state_e state
);
    pd_state_e state_nx;

    always_comb begin
        state_nx = state;
        case (state)
            ST_RUN:   if (!active) state_nx = ST_FLUSH;
            ST_FLUSH: begin
                if (active)       state_nx = ST_RUN;
                else if (expired) state_nx = ST_DOWN;
            end
            ST_DOWN: begin
                if (active)          state_nx = ST_RUN;
                else if (!autopd_en) state_nx = ST_FLUSH;
            end
            default: state_nx = ST_RUN;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state <= ST_RUN;
        else     state <= state_nx;
    end
endmodule

// File: rtl/txen_pd_ctrl.sv
module txen_pd_ctrl
    import txpd_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int FLUSH_2X    = 32,
    parameter int FLUSH_4X    = 64,
    parameter int FLUSH_8X    = 128
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       txen_in,
    input  logic       txen_invert,
    input  logic       autopd_en,
    input  logic [1:0] interp_sel,
    input  logic       sleep_req,
    input  logic       full_pd_req,
    output logic       flush_zero,
    output logic       digital_pd,
    output logic       dac_out_off,
    output logic       ref_pd,
    output logic [1:0] pd_state
);
    localparam int MAX_LEN = (FLUSH_8X > FLUSH_4X) ?
                             ((FLUSH_8X > FLUSH_2X) ? FLUSH_8X : FLUSH_2X) :
                             ((FLUSH_4X > FLUSH_2X) ? FLUSH_4X : FLUSH_2X);
    localparam int CNT_W   = $clog2(MAX_LEN + 1);

    logic             txen_s;
    logic             rx_active;
    logic             expired;
    logic [CNT_W-1:0] limit;
    pd_state_e        state;
    pd_ctl_t          ctl;

    txen_sync #(.STAGES(SYNC_STAGES)) i_sync (
        .clk     (clk),
        .rst     (rst),
        .d_async (txen_in),
        .q_sync  (txen_s)
    );

    assign rx_active = txen_s ^ txen_invert;
    assign limit     = CNT_W'(flush_cycles(interp_sel, FLUSH_2X, FLUSH_4X, FLUSH_8X));

    flush_timer #(.CNT_W(CNT_W)) i_timer (
        .clk     (clk),
        .rst     (rst),
        .run     ((state == ST_FLUSH) && autopd_en),
        .limit   (limit),
        .expired (expired)
    );

    txen_fsm i_fsm (
        .clk       (clk),
        .rst       (rst),
        .active    (rx_active),
        .autopd_en (autopd_en),
        .expired   (expired),
        .state     (state)
    );

    always_comb begin
        ctl.flush_zero  = (state != ST_RUN);
        ctl.digital_pd  = (state == ST_DOWN) || full_pd_req;
        ctl.dac_out_off = sleep_req || full_pd_req;
        ctl.ref_pd      = full_pd_req;
    end

    assign flush_zero  = ctl.flush_zero;
    assign digital_pd  = ctl.digital_pd;
    assign dac_out_off = ctl.dac_out_off;
    assign ref_pd      = ctl.ref_pd;
    assign pd_state    = state;
endmodule

// File: rtl/txpd_checker.sv
module txpd_checker
    import txpd_pkg::*;
#(
    parameter int FLUSH_2X = 32,
    parameter int FLUSH_4X = 64,
    parameter int FLUSH_8X = 128
) (
    input logic       clk,
    input logic       rst,
    input logic       active,
    input logic       autopd_en,
    input logic [1:0] interp_sel,
    input logic       sleep_req,
    input logic       full_pd_req,
    input logic       digital_pd,
    input logic       dac_out_off,
    input logic       ref_pd,
    input logic [1:0] pd_state
);
    int unsigned flush_run;

    always_ff @(posedge clk) begin
        if (rst) flush_run <= 0;
        else if (pd_state == 2'd1 && autopd_en) flush_run <= flush_run + 1;
        else flush_run <= 0;
    end

    // R1
    reset_to_run_chk: assert property (@(posedge clk) rst |=> pd_state == 2'd0);

    // R5
    pd_after_full_flush_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(pd_state == 2'd2) |->
            (flush_run == flush_cycles(interp_sel, FLUSH_2X, FLUSH_4X, FLUSH_8X)));

    // R4
    no_pd_without_auto_chk: assert property (@(posedge clk) disable iff (rst)
        !autopd_en |=> pd_state != 2'd2);

    // R7
    reactivate_to_run_chk: assert property (@(posedge clk) disable iff (rst)
        (pd_state != 2'd0 && active) |=> pd_state == 2'd0);

    // R8
    analog_untouched_chk: assert property (@(posedge clk) disable iff (rst)
        (!sleep_req && !full_pd_req) |-> (!dac_out_off && !ref_pd));

    // R10
    full_pd_all_off_chk: assert property (@(posedge clk) disable iff (rst)
        full_pd_req |-> (digital_pd && ref_pd && dac_out_off));
endmodule

bind txen_pd_ctrl txpd_checker #(
    .FLUSH_2X (FLUSH_2X),
    .FLUSH_4X (FLUSH_4X),
    .FLUSH_8X (FLUSH_8X)
) i_txpd_checker (
    .clk         (clk),
    .rst         (rst),
    .active      (rx_active),
    .autopd_en   (autopd_en),
    .interp_sel  (interp_sel),
    .sleep_req   (sleep_req),
    .full_pd_req (full_pd_req),
    .digital_pd  (digital_pd),
    .dac_out_off (dac_out_off),
    .ref_pd      (ref_pd),
    .pd_state    (pd_state)
);

// File: tb/test_txen_pd_ctrl.sv
module test_txen_pd_ctrl;
    localparam time CLK_PERIOD = 10ns;
    localparam int  NV = 18;

    typedef struct packed {
        logic       inv;
        logic       tx;
        logic       ap;
        logic [1:0] sel;
        logic       sl;
        logic       fp;
        logic [7:0] wait_n;
        logic [1:0] st;
        logic       fz;
        logic       dpd;
        logic       doff;
        logic       rpd;
    } vec_t;

    //                      inv  tx   ap   sel   sl   fp   wait  st   fz   dpd  doff rpd
    localparam vec_t VECS [NV] = '{
        '{1'b0,1'b1,1'b1,2'd0,1'b0,1'b0,8'd3,  2'd0,1'b0,1'b0,1'b0,1'b0},
        '{1'b0,1'b0,1'b1,2'd0,1'b0,1'b0,8'd3,  2'd1,1'b1,1'b0,1'b0,1'b0},
        '{1'b0,1'b0,1'b1,2'd0,1'b0,1'b0,8'd30, 2'd1,1'b1,1'b0,1'b0,1'b0},
        '{1'b0,1'b0,1'b1,2'd0,1'b0,1'b0,8'd1,  2'd1,1'b1,1'b0,1'b0,1'b0},
        '{1'b0,1'b0,1'b1,2'd0,1'b0,1'b0,8'd1,  2'd2,1'b1,1'b1,1'b0,1'b0},
        '{1'b0,1'b1,1'b1,2'd0,1'b0,1'b0,8'd3,  2'd0,1'b0,1'b0,1'b0,1'b0},
        '{1'b1,1'b1,1'b1,2'd1,1'b0,1'b0,8'd3,  2'd1,1'b1,1'b0,1'b0,1'b0},
        '{1'b1,1'b1,1'b1,2'd1,1'b0,1'b0,8'd61, 2'd1,1'b1,1'b0,1'b0,1'b0},
        '{1'b1,1'b1,1'b1,2'd1,1'b0,1'b0,8'd1,  2'd2,1'b1,1'b1,1'b0,1'b0},
        '{1'b1,1'b0,1'b1,2'd1,1'b0,1'b0,8'd3,  2'd0,1'b0,1'b0,1'b0,1'b0},
        '{1'b1,1'b1,1'b0,2'd2,1'b0,1'b0,8'd3,  2'd1,1'b1,1'b0,1'b0,1'b0},
        '{1'b1,1'b1,1'b0,2'd2,1'b0,1'b0,8'd200,2'd1,1'b1,1'b0,1'b0,1'b0},
        '{1'b1,1'b1,1'b1,2'd2,1'b0,1'b0,8'd127,2'd1,1'b1,1'b0,1'b0,1'b0},
        '{1'b1,1'b1,1'b1,2'd2,1'b0,1'b0,8'd1,  2'd2,1'b1,1'b1,1'b0,1'b0},
        '{1'b1,1'b1,1'b1,2'd2,1'b1,1'b0,8'd1,  2'd2,1'b1,1'b1,1'b1,1'b0},
        '{1'b1,1'b0,1'b1,2'd2,1'b0,1'b1,8'd3,  2'd0,1'b0,1'b1,1'b1,1'b1},
        '{1'b1,1'b0,1'b1,2'd2,1'b0,1'b0,8'd1,  2'd0,1'b0,1'b0,1'b0,1'b0},
        '{1'b1,1'b0,1'b1,2'd3,1'b0,1'b0,8'd1,  2'd0,1'b0,1'b0,1'b0,1'b0}
    };

    localparam string TAGS [NV] = '{
        "R2", "R3", "R5", "R5", "R5 R8", "R2", "R6", "R5", "R6 R5",
        "R6 R7", "R4", "R4", "R5", "R5", "R9", "R10", "R2", "R2"
    };

    logic       clk = 1'b0;
    logic       rst;
    logic       txen_in, txen_invert, autopd_en, sleep_req, full_pd_req;
    logic [1:0] interp_sel;
    logic       flush_zero, digital_pd, dac_out_off, ref_pd;
    logic [1:0] pd_state;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    txen_pd_ctrl i_txen_pd_ctrl (
        .clk         (clk),
        .rst         (rst),
        .txen_in     (txen_in),
        .txen_invert (txen_invert),
        .autopd_en   (autopd_en),
        .interp_sel  (interp_sel),
        .sleep_req   (sleep_req),
        .full_pd_req (full_pd_req),
        .flush_zero  (flush_zero),
        .digital_pd  (digital_pd),
        .dac_out_off (dac_out_off),
        .ref_pd      (ref_pd),
        .pd_state    (pd_state)
    );

    task automatic step(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic expect_out(input string tag, input logic [1:0] st, input logic fz,
                              input logic dpd, input logic doff, input logic rpd);
        checks++;
        if (pd_state !== st || flush_zero !== fz || digital_pd !== dpd ||
            dac_out_off !== doff || ref_pd !== rpd) begin
            errors++;
            $display("FAIL %s: got st=%0d fz=%b dpd=%b doff=%b rpd=%b, expected st=%0d fz=%b dpd=%b doff=%b rpd=%b",
                     tag, pd_state, flush_zero, digital_pd, dac_out_off, ref_pd,
                     st, fz, dpd, doff, rpd);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        checks++;
        errors++;
        $display("FAIL watchdog: got timeout, expected completion");
        finish_run();
    end

    initial begin
        rst = 1'b1; txen_in = 1'b1; txen_invert = 1'b0; autopd_en = 1'b1;
        interp_sel = 2'd0; sleep_req = 1'b0; full_pd_req = 1'b0;
        step(3);
        // R1: reset state
        expect_out("R1", 2'd0, 1'b0, 1'b0, 1'b0, 1'b0);
        rst = 1'b0;
        step(1);

        for (int i = 0; i < NV; i++) begin
            txen_invert = VECS[i].inv;
            txen_in     = VECS[i].tx;
            autopd_en   = VECS[i].ap;
            interp_sel  = VECS[i].sel;
            sleep_req   = VECS[i].sl;
            full_pd_req = VECS[i].fp;
            step(int'(VECS[i].wait_n));
            expect_out(TAGS[i], VECS[i].st, VECS[i].fz, VECS[i].dpd,
                       VECS[i].doff, VECS[i].rpd);
        end

        // R7: re-enable in the middle of a 2x flush
        txen_invert = 1'b0; txen_in = 1'b0; interp_sel = 2'd0;
        step(3);
        expect_out("R3", 2'd1, 1'b1, 1'b0, 1'b0, 1'b0);
        step(20);
        txen_in = 1'b1;
        step(3);
        expect_out("R7", 2'd0, 1'b0, 1'b0, 1'b0, 1'b0);

        // R7: the following flush runs its full length of 32 cycles
        txen_in = 1'b0;
        step(34);
        expect_out("R7", 2'd1, 1'b1, 1'b0, 1'b0, 1'b0);
        step(1);
        expect_out("R7", 2'd2, 1'b1, 1'b1, 1'b0, 1'b0);

        // R1: reset from powered-down
        rst = 1'b1;
        step(1);
        expect_out("R1", 2'd0, 1'b0, 1'b0, 1'b0, 1'b0);
        rst = 1'b0;
        txen_in = 1'b1;
        step(3);
        expect_out("R2", 2'd0, 1'b0, 1'b0, 1'b0, 1'b0);

        finish_run();
    end
endmodule